// File: doc/BRIEF.md
# Guarded Byte-Store Write Controller

This block sits between a CPU register bus and a small byte-wide storage array. The bus sees four byte registers: a target address, a data byte, a control byte and an unlock register that only accepts writes. A read needs one control write and nothing else. The addressed byte is latched into the data register at the same clock edge, so software can fetch it one cycle later.

A write to the array is guarded three ways. First, two key bytes must reach the unlock register back to back, 0x55 and then 0xAA. The very next bus access must then be a control write that asks for a start. Second, that same control write must also keep the enable bit set. Third, a power-up hold timer must have expired. A started write runs for a fixed number of cycles. During that time new reads and writes are refused. When it ends, the in-progress bit drops and a sticky completion flag rises.

Top module: `nvw_ctrl`

## Requirements
- R1: Bus writes to selector 0 (address) and selector 1 (data) load those registers, and both read back unchanged on `bus_rdata`.
- R2: An array write starts only when three accesses come in a row: a write of 0x55 to selector 3, a write of 0xAA to selector 3, then a control write with bit 1 (start) set. A wrong key value, or any other bus read or write between these steps, returns the sequence to its start, and the write does not begin.
- R3: Control register (selector 2) bit 0 is the enable bit, and it resets to 0. A start is refused unless the same control write also sets bit 0. Hardware never clears bit 0.
- R4: Once a write has started, clearing the enable bit does not stop it, and the byte is still stored.
- R5: A started write stays in progress for WRITE_CYCLES cycles, shown as control bit 1 reading 1. At the end, bit 1 returns to 0 and the done flag (control bit 3) becomes 1. Only a control write with bit 3 = 0 clears the flag, and a control write with bit 3 = 1 never sets it.
- R6: For HOLD_MS milliseconds at CLK_HZ after reset, a fully unlocked and enabled start is refused and the array is not changed.
- R7: A control write with bit 2 (read) set loads the array byte at the current address into the data register, so it is readable on the next cycle. The data register then keeps that value until another read or a data write, including when the address changes.
- R8: While a write is in progress, start and read requests are ignored.
- R9: Selector 3 always reads as 0x00. Each byte needs its own fresh unlock, because a start without a new key pair is refused.
- R10: After reset every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Register selector: 0 address, 1 data, 2 control, 3 unlock |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; it only matters to the unlock sequence |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |

## Verification
A wrong unlock state shows up at the very next control read. The in-progress bit either rises when it should not or fails to rise, one cycle after the start attempt. A write-timer fault changes the number of cycles that bit 1 reads high, and this count is measured exactly. A bad gate on read or start shows up as a wrong byte in the data register one cycle after the request. Corrupted array contents appear as soon as the affected address is read back.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_KEY  = 2'd3
    } reg_sel_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_HALF  = 2'd1,
        UL_ARMED = 2'd2
    } unlock_e;

    typedef struct packed {
        logic keep_done;
        logic rd;
        logic go;
        logic en;
    } ctrl_req_t;

    function automatic ctrl_req_t decode_ctrl(input logic [7:0] v);
        ctrl_req_t r;
        r.en        = v[0];
        r.go        = v[1];
        r.rd        = v[2];
        r.keep_done = v[3];
        return r;
    endfunction

    function automatic logic [7:0] pack_ctrl(input logic en, input logic wip, input logic done);
        return {4'b0000, done, 1'b0, wip, en};
    endfunction

    function automatic int hold_cycles(input int clk_hz, input int ms);
        return (clk_hz / 1000) * ms;
    endfunction

endpackage

// File: rtl/nvw_unlock.sv
module nvw_unlock
    import nvw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_any,
    input  logic       key_wr,
    input  logic [7:0] key_val,
    output logic       armed
);
    unlock_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= UL_IDLE;
        end else if (acc_any) begin
            if (key_wr) begin
                case (state_q)
                    UL_IDLE: state_q <= (key_val == KEY_FIRST)  ? UL_HALF  : UL_IDLE;
                    UL_HALF: state_q <= (key_val == KEY_SECOND) ? UL_ARMED : UL_IDLE;
                    default: state_q <= UL_IDLE;
                endcase
            end else begin
                state_q <= UL_IDLE;
            end
        end
    end

    assign armed = (state_q == UL_ARMED);
endmodule

// File: rtl/nvw_holdoff.sv
module nvw_holdoff #(
    parameter int HOLD_CYC = 8000000
) (
    input  logic clk,
    input  logic rst,
    output logic hold_active
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC + 1) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hold_active = (cnt_q != LIMIT);
endmodule

// File: rtl/nvw_array.sv
module nvw_array #(
    parameter int DEPTH        = 256,
    parameter int WRITE_CYCLES = 500000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     go,
    input  logic [$clog2(DEPTH)-1:0] go_addr,
    input  logic [7:0]               go_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [7:0]               rd_data,
    output logic                     busy,
    output logic                     done
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WRITE_CYCLES - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } pend_t;

    logic [7:0]    mem_q [DEPTH];
    pend_t         pend_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;

    assign done    = busy_q && (cnt_q == LAST);
    assign busy    = busy_q;
    assign rd_data = mem_q[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            pend_q <= '0;
        end else if (go && !busy_q) begin
            busy_q      <= 1'b1;
            cnt_q       <= '0;
            pend_q.addr <= go_addr;
            pend_q.data <= go_data;
        end else if (done) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else if (done) begin
            mem_q[pend_q.addr] <= pend_q.data;
        end
    end
endmodule

// File: rtl/nvw_ctrl.sv
module nvw_ctrl
    import nvw_pkg::*;
#(
    parameter int DEPTH        = 256,
    parameter int WRITE_CYCLES = 500000,
    parameter int CLK_HZ       = 125000000,
    parameter int HOLD_MS      = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    localparam int AW       = $clog2(DEPTH);
    localparam int HOLD_CYC = hold_cycles(CLK_HZ, HOLD_MS);

    reg_sel_e  sel;
    ctrl_req_t req;
    logic [7:0] addr_q, data_q;
    logic       en_q, flag_q;
    logic       armed, hold_active, busy, done;
    logic [7:0] arr_rd;
    logic       wr_ctrl, go, do_read;

    assign sel     = reg_sel_e'(bus_sel);
    assign req     = decode_ctrl(bus_wdata);
    assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
    assign go      = wr_ctrl && req.go && req.en && armed && !hold_active && !busy;
    assign do_read = wr_ctrl && req.rd && !go && !busy;

    nvw_unlock unlock_i (
        .clk     (clk),
        .rst     (rst),
        .acc_any (bus_wr || bus_rd),
        .key_wr  (bus_wr && (sel == SEL_KEY)),
        .key_val (bus_wdata),
        .armed   (armed)
    );

    nvw_holdoff #(.HOLD_CYC(HOLD_CYC)) hold_i (
        .clk         (clk),
        .rst         (rst),
        .hold_active (hold_active)
    );

    nvw_array #(.DEPTH(DEPTH), .WRITE_CYCLES(WRITE_CYCLES)) array_i (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .go_addr (addr_q[AW-1:0]),
        .go_data (data_q),
        .rd_addr (addr_q[AW-1:0]),
        .rd_data (arr_rd),
        .busy    (busy),
        .done    (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            en_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (bus_wr && sel == SEL_ADDR) addr_q <= bus_wdata;
            if (bus_wr && sel == SEL_DATA) data_q <= bus_wdata;
            else if (do_read)              data_q <= arr_rd;
            if (wr_ctrl) en_q <= req.en;
            if (done)                            flag_q <= 1'b1;
            else if (wr_ctrl && !req.keep_done)  flag_q <= 1'b0;
        end
    end

    always_comb begin
        case (sel)
            SEL_ADDR: bus_rdata = addr_q;
            SEL_DATA: bus_rdata = data_q;
            SEL_CTRL: bus_rdata = pack_ctrl(en_q, busy, flag_q);
            default:  bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/nvw_ctrl_chk.sv
module nvw_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] bus_sel,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       en_q,
    input logic       flag_q,
    input logic       busy,
    input logic       armed,
    input logic       hold_active
);
    p_start_unlocked_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(armed));

    p_start_enabled_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> en_q);

    p_enable_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (en_q && !(bus_wr && bus_sel == 2'd2)) |=> en_q);

    p_done_flag_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> flag_q);

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !(bus_wr && bus_sel == 2'd2 && !bus_wdata[3])) |=> flag_q);

    p_no_start_in_hold_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !hold_active);

    p_key_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == 2'd3) |-> (bus_rdata == 8'h00));
endmodule

bind nvw_ctrl nvw_ctrl_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .en_q        (en_q),
    .flag_q      (flag_q),
    .busy        (busy),
    .armed       (armed),
    .hold_active (hold_active)
);

// File: tb/nvw_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvw_ctrl_tb_top;
    localparam int WR_CYC = 8;
    localparam int HOLD   = 40;   // CLK_HZ 1000 * HOLD_MS 40 / 1000

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_sel = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    nvw_ctrl #(.DEPTH(16), .WRITE_CYCLES(WR_CYC), .CLK_HZ(1000), .HOLD_MS(40)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // op: 0 write, 1 read and compare, 2 idle until a write finishes
    typedef struct packed {
        logic [1:0] op;
        logic [1:0] sel;
        logic [7:0] wd;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 63;
    localparam vec_t VEC [NV] = '{
        {2'd0,2'd0,8'h05,8'h00,4'd1},  // R1
        {2'd1,2'd0,8'h00,8'h05,4'd1},
        {2'd0,2'd1,8'h3C,8'h00,4'd1},
        {2'd1,2'd1,8'h00,8'h3C,4'd1},
        {2'd0,2'd3,8'h55,8'h00,4'd2},  // R2 good unlock
        {2'd0,2'd3,8'hAA,8'h00,4'd2},
        {2'd0,2'd2,8'h03,8'h00,4'd2},
        {2'd1,2'd2,8'h00,8'h03,4'd5},  // R5 in progress
        {2'd0,2'd2,8'h00,8'h00,4'd4},  // R4 clear enable mid-write
        {2'd0,2'd2,8'h04,8'h00,4'd8},  // R8 read while busy
        {2'd1,2'd2,8'h00,8'h02,4'd4},
        {2'd1,2'd1,8'h00,8'h3C,4'd8},
        {2'd2,2'd0,8'h00,8'h00,4'd5},
        {2'd1,2'd2,8'h00,8'h08,4'd5},
        {2'd0,2'd1,8'h00,8'h00,4'd7},  // R7
        {2'd0,2'd2,8'h0C,8'h00,4'd7},
        {2'd1,2'd1,8'h00,8'h3C,4'd7},
        {2'd1,2'd2,8'h00,8'h08,4'd5},
        {2'd0,2'd2,8'h00,8'h00,4'd5},
        {2'd1,2'd2,8'h00,8'h00,4'd5},
        {2'd0,2'd2,8'h08,8'h00,4'd5},
        {2'd1,2'd2,8'h00,8'h00,4'd5},
        {2'd0,2'd0,8'h06,8'h00,4'd2},  // R2 wrong key
        {2'd0,2'd1,8'h11,8'h00,4'd2},
        {2'd0,2'd3,8'h55,8'h00,4'd2},
        {2'd0,2'd3,8'h00,8'h00,4'd2},
        {2'd0,2'd3,8'hAA,8'h00,4'd2},
        {2'd0,2'd2,8'h03,8'h00,4'd2},
        {2'd1,2'd2,8'h00,8'h01,4'd2},
        {2'd0,2'd2,8'h05,8'h00,4'd10}, // R10
        {2'd1,2'd1,8'h00,8'hFF,4'd10},
        {2'd0,2'd3,8'h55,8'h00,4'd2},  // R2 access between keys
        {2'd1,2'd0,8'h00,8'h06,4'd2},
        {2'd0,2'd3,8'hAA,8'h00,4'd2},
        {2'd0,2'd2,8'h03,8'h00,4'd2},
        {2'd1,2'd2,8'h00,8'h01,4'd2},
        {2'd0,2'd2,8'h00,8'h00,4'd3},  // R3 start without enable
        {2'd0,2'd3,8'h55,8'h00,4'd3},
        {2'd0,2'd3,8'hAA,8'h00,4'd3},
        {2'd0,2'd2,8'h02,8'h00,4'd3},
        {2'd1,2'd2,8'h00,8'h00,4'd3},
        {2'd0,2'd1,8'h11,8'h00,4'd9},  // R9 one unlock per byte
        {2'd0,2'd3,8'h55,8'h00,4'd9},
        {2'd0,2'd3,8'hAA,8'h00,4'd9},
        {2'd0,2'd2,8'h03,8'h00,4'd9},
        {2'd2,2'd0,8'h00,8'h00,4'd9},
        {2'd1,2'd2,8'h00,8'h09,4'd3},
        {2'd0,2'd1,8'h22,8'h00,4'd9},
        {2'd0,2'd2,8'h0B,8'h00,4'd9},
        {2'd1,2'd2,8'h00,8'h09,4'd9},
        {2'd0,2'd2,8'h0D,8'h00,4'd7},
        {2'd1,2'd1,8'h00,8'h11,4'd7},
        {2'd0,2'd1,8'h77,8'h00,4'd8},  // R8 start while busy
        {2'd0,2'd3,8'h55,8'h00,4'd8},
        {2'd0,2'd3,8'hAA,8'h00,4'd8},
        {2'd0,2'd2,8'h0B,8'h00,4'd8},
        {2'd0,2'd0,8'h07,8'h00,4'd8},
        {2'd0,2'd3,8'h55,8'h00,4'd8},
        {2'd0,2'd3,8'hAA,8'h00,4'd8},
        {2'd0,2'd2,8'h0B,8'h00,4'd8},
        {2'd2,2'd0,8'h00,8'h00,4'd8},
        {2'd0,2'd2,8'h0D,8'h00,4'd8},
        {2'd1,2'd1,8'h00,8'hFF,4'd8}
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] sel, input logic [7:0] d);
        bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] sel, output logic [7:0] v);
        bus_sel = sel; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state: R1, R3, R9
        do_rd(2'd0, v); check(1, v, 8'h00);
        do_rd(2'd1, v); check(1, v, 8'h00);
        do_rd(2'd2, v); check(3, v, 8'h00);
        do_rd(2'd3, v); check(9, v, 8'h00);
        // R6: full unlocked start inside the hold window is refused
        do_wr(2'd0, 8'h01);
        do_wr(2'd1, 8'h5A);
        do_wr(2'd3, 8'h55);
        do_wr(2'd3, 8'hAA);
        do_wr(2'd2, 8'h03);
        do_rd(2'd2, v); check(6, v, 8'h01);
        repeat (HOLD + 5) @(negedge clk);
        do_wr(2'd2, 8'h05);
        do_rd(2'd1, v); check(6, v, 8'hFF);
        // table walk
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: do_wr(VEC[i].sel, VEC[i].wd);
                2'd1: begin
                    do_rd(VEC[i].sel, v);
                    check(int'(VEC[i].req), v, VEC[i].exp);
                end
                default: repeat (WR_CYC + 4) @(negedge clk);
            endcase
        end
        // R5: exact write duration
        do_wr(2'd0, 8'h09);
        do_wr(2'd1, 8'hC3);
        do_wr(2'd3, 8'h55);
        do_wr(2'd3, 8'hAA);
        do_wr(2'd2, 8'h03);
        n = 0;
        for (int k = 0; k < 50; k++) begin
            do_rd(2'd2, v);
            if (v[1]) n++;
            else break;
        end
        check(5, 8'(n), 8'(WR_CYC));
        check(5, v, 8'h09);
        do_wr(2'd2, 8'h05);
        do_rd(2'd1, v); check(5, v, 8'hC3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule